// File: doc/BRIEF.md
# Hamming ECC Syndrome Corrector

This block takes two 24-bit Hamming check codes for one 512-byte data chunk. The first is the code read back from the spare area. The second is the code computed from the data just read. The block turns both into 32-bit words with a fixed bit placement and forms their XOR syndrome. It counts the set bits of the syndrome in a combinational adder tree. It then registers one of four verdicts: clean, correctable single-bit data error, corrupted check field, or uncorrectable error.

For a correctable error the block also registers the byte index and the bit index that a downstream buffer writer must flip. An erased chunk is reported as clean. In that case every stored check byte reads 0xFF and the computed code is zero, which would otherwise look like a heavy error.

The two codes arrive on a valid/ready handshake. The verdict appears one clock later with a single-cycle valid pulse and then holds until the next accepted pair.

Top module: `hamming_syndrome_corrector`

## Requirements
- R1: A code is given as three bytes: byte0 = code[7:0], byte1 = code[15:8], byte2 = code[23:16]. Each code is placed into a 32-bit word with byte0 at bits 7:0, byte1 at bits 23:16, byte2[7:4] at bits 27:24 and byte2[3:0] at bits 11:8; all other bits are zero. Equal codes give a zero syndrome and status 0 (clean).
- R2: If the syndrome has exactly 12 set bits, the status is 1 (corrected). The byte index is syndrome[27:19] and the bit index is syndrome[18:16]. Only the weight decides this verdict, not the pattern of the bits.
- R3: If the syndrome has exactly one set bit, the status is 2 (check field corrupted).
- R4: If the stored code is 0xFFFFFF and the computed code is 0x000000, the status is 0 (erased chunk). This check takes priority over the weight-based verdicts. The swapped pair (stored zero, computed all ones) is not exempt.
- R5: Any other nonzero syndrome gives status 3 (uncorrectable), including weights 2, 11, 13 and 23.
- R6: out_byte and out_bit are zero whenever out_status is not 1.
- R7: out_valid is high for exactly the one cycle after each edge where in_valid and in_ready are both high. With no accepted input, out_valid stays low and the result outputs hold their values. Back-to-back inputs give back-to-back results.
- R8: While rst_n is low, out_valid, out_status, out_byte, out_bit and in_ready are all zero. in_ready goes high on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A code pair is offered |
| in_ready | output | 1 | Block accepts a code pair |
| stored_code | input | 24 | Check code read from the spare area |
| calc_code | input | 24 | Check code computed over the data |
| out_valid | output | 1 | One-cycle pulse: new verdict present |
| out_status | output | 2 | 0 clean, 1 corrected, 2 check field error, 3 uncorrectable |
| out_byte | output | 9 | Byte index to flip (status 1 only) |
| out_bit | output | 3 | Bit index within the byte (status 1 only) |

## Verification
The bench builds the block with its default parameters: a 24-bit code, a 9-bit byte index and a 3-bit bit index. With these values both ends of the address range can be reached, byte 0 bit 0 and byte 511 bit 7. They also allow syndromes of weight 11, 12 and 13 on either side of the correction criterion. The erased pattern is applied in both orientations of the two codes, so that its priority over the weight-based verdicts shows at the ports.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  localparam int CODE_W     = 24;
  localparam int SYN_W      = 32;
  localparam int HALF_LSB   = 16;
  localparam int BIT_W      = 3;
  localparam int BYTE_W     = 9;
  localparam int ADDR_W     = BYTE_W + BIT_W;
  localparam int CNT_W      = $clog2(SYN_W + 1);
  localparam int FIX_WEIGHT = 12;
  localparam int FIELD_WEIGHT = 1;

  localparam logic [SYN_W-1:0]  ERASED_STORED_W = 32'h0FFF_0FFF;
  localparam logic [SYN_W-1:0]  ERASED_CALC_W   = '0;

  typedef enum logic [1:0] {
    ST_CLEAN     = 2'd0,
    ST_FIXED     = 2'd1,
    ST_FIELD_ERR = 2'd2,
    ST_MULTI     = 2'd3
  } status_e;

  typedef struct packed {
    status_e           status;
    logic [BYTE_W-1:0] byte_idx;
    logic [BIT_W-1:0]  bit_idx;
  } verdict_t;

  // Bit placement of a 3-byte code inside a 32-bit word.
  function automatic logic [SYN_W-1:0] place_code(input logic [CODE_W-1:0] c);
    logic [SYN_W-1:0] w;
    w        = '0;
    w[7:0]   = c[7:0];
    w[23:16] = c[15:8];
    w[27:24] = c[23:20];
    w[11:8]  = c[19:16];
    return w;
  endfunction

  // Error address carried in the upper half of the syndrome.
  function automatic logic [ADDR_W-1:0] err_addr(input logic [SYN_W-1:0] s);
    return s[HALF_LSB +: ADDR_W];
  endfunction

  function automatic logic is_erased(input logic [SYN_W-1:0] stored_w,
                                     input logic [SYN_W-1:0] calc_w);
    return (stored_w == ERASED_STORED_W) && (calc_w == ERASED_CALC_W);
  endfunction

endpackage

// File: rtl/hsc_place.sv
module hsc_place
  import hsc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [SYN_W-1:0]  word
);

  always_comb word = place_code(code);

endmodule

// File: rtl/hsc_popcount.sv
module hsc_popcount #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);

  localparam int LV = (W <= 1) ? 1 : $clog2(W);
  localparam int NL = 1 << LV;

  // Heap-indexed tree: leaves at NL..2*NL-1, root at 1.
  logic [CW-1:0] node [1:2*NL-1];

  generate
    for (genvar i = 0; i < NL; i++) begin : g_leaf
      if (i < W) begin : g_real
        assign node[NL+i] = {{(CW-1){1'b0}}, vec[i]};
      end else begin : g_pad
        assign node[NL+i] = '0;
      end
    end
    for (genvar j = 1; j < NL; j++) begin : g_sum
      assign node[j] = node[2*j] + node[2*j+1];
    end
  endgenerate

  assign cnt = node[1];

endmodule

// File: rtl/hsc_classify.sv
module hsc_classify
  import hsc_pkg::*;
(
  input  logic [SYN_W-1:0] stored_w,
  input  logic [SYN_W-1:0] calc_w,
  input  logic [SYN_W-1:0] syn,
  input  logic [CNT_W-1:0] weight,
  output logic             erased,
  output verdict_t         verdict
);

  logic [ADDR_W-1:0] addr;

  always_comb begin
    erased  = is_erased(stored_w, calc_w);
    addr    = err_addr(syn);
    verdict = '{status: ST_CLEAN, byte_idx: '0, bit_idx: '0};
    if (erased) begin
      verdict.status = ST_CLEAN;
    end else if (syn == '0) begin
      verdict.status = ST_CLEAN;
    end else if (weight == CNT_W'(FIX_WEIGHT)) begin
      verdict.status   = ST_FIXED;
      verdict.byte_idx = addr[ADDR_W-1:BIT_W];
      verdict.bit_idx  = addr[BIT_W-1:0];
    end else if (weight == CNT_W'(FIELD_WEIGHT)) begin
      verdict.status = ST_FIELD_ERR;
    end else begin
      verdict.status = ST_MULTI;
    end
  end

endmodule

// File: rtl/hamming_syndrome_corrector.sv
module hamming_syndrome_corrector
  import hsc_pkg::*;
#(
  parameter int CODE_BITS = hsc_pkg::CODE_W,
  parameter int BYTE_BITS = hsc_pkg::BYTE_W,
  parameter int BIT_BITS  = hsc_pkg::BIT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [CODE_BITS-1:0] stored_code,
  input  logic [CODE_BITS-1:0] calc_code,
  output logic                 out_valid,
  output logic [1:0]           out_status,
  output logic [BYTE_BITS-1:0] out_byte,
  output logic [BIT_BITS-1:0]  out_bit
);

  // Named internal events, observed by the assertions below.
  logic             in_fire;
  logic [SYN_W-1:0] stored_w;
  logic [SYN_W-1:0] calc_w;
  logic [SYN_W-1:0] syndrome;
  logic [CNT_W-1:0] syn_weight;
  logic             erased_hit;
  verdict_t         verdict_d;
  verdict_t         verdict_q;
  logic             ready_q;
  logic             valid_q;

  assign in_fire = in_valid && ready_q;

  hsc_place u_place_stored (.code(stored_code), .word(stored_w));
  hsc_place u_place_calc   (.code(calc_code),   .word(calc_w));

  assign syndrome = stored_w ^ calc_w;

  hsc_popcount #(.W(SYN_W), .CW(CNT_W)) u_weight (
    .vec(syndrome),
    .cnt(syn_weight)
  );

  hsc_classify u_classify (
    .stored_w(stored_w),
    .calc_w  (calc_w),
    .syn     (syndrome),
    .weight  (syn_weight),
    .erased  (erased_hit),
    .verdict (verdict_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      valid_q   <= 1'b0;
      verdict_q <= '{status: ST_CLEAN, byte_idx: '0, bit_idx: '0};
    end else begin
      ready_q <= 1'b1;
      valid_q <= in_fire;
      if (in_fire) verdict_q <= verdict_d;
    end
  end

  assign in_ready   = ready_q;
  assign out_valid  = valid_q;
  assign out_status = verdict_q.status;
  assign out_byte   = BYTE_BITS'(verdict_q.byte_idx);
  assign out_bit    = BIT_BITS'(verdict_q.bit_idx);

  // The adder tree must agree with a direct bit count.
  assert_weight_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> (syn_weight == CNT_W'($countones(syndrome))));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_fire));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_fire |=> ($stable(out_status) && $stable(out_byte) && $stable(out_bit)));

  assert_addr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_status != 2'd1) |-> (out_byte == '0 && out_bit == '0));

  assert_erased_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && erased_hit) |=> (out_status == 2'd0));

  assert_field_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !erased_hit && $countones(syndrome) == 1) |=> (out_status == 2'd2));

endmodule

// File: tb/sim_hamming_syndrome_corrector.sv
module sim_hamming_syndrome_corrector;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] stored_code = '0;
  logic [23:0] calc_code = '0;
  logic        out_valid;
  logic [1:0]  out_status;
  logic [8:0]  out_byte;
  logic [2:0]  out_bit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hamming_syndrome_corrector u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .stored_code(stored_code), .calc_code(calc_code),
    .out_valid(out_valid), .out_status(out_status),
    .out_byte(out_byte), .out_bit(out_bit)
  );

  // {stored, calc, status, byte, bit}, values worked out from the requirements.
  localparam int NV = 17;
  localparam logic [61:0] VECS [NV] = '{
    {24'hABCDEF, 24'hABCDEF, 2'd0, 9'd0,   3'd0},  // R1 equal codes
    {24'h000000, 24'h000000, 2'd0, 9'd0,   3'd0},  // R1 all zero
    {24'h0F00FF, 24'h000000, 2'd1, 9'd0,   3'd0},  // R2 address 0x000
    {24'hF0FF00, 24'h000000, 2'd1, 9'd511, 3'd7},  // R2 address 0xFFF
    {24'h5AA35C, 24'h000000, 2'd1, 9'd180, 3'd3},  // R2 address 0x5A3
    {24'h48970A, 24'h123456, 2'd1, 9'd180, 3'd3},  // R2 same syndrome, other codes
    {24'h000FFF, 24'h000000, 2'd1, 9'd1,   3'd7},  // R2 weight only decides
    {24'h000001, 24'h000000, 2'd2, 9'd0,   3'd0},  // R3 byte0 bit0
    {24'h100000, 24'h000000, 2'd2, 9'd0,   3'd0},  // R3 byte2 bit4
    {24'h000000, 24'h800000, 2'd2, 9'd0,   3'd0},  // R3 computed side
    {24'hFFFFFF, 24'h000000, 2'd0, 9'd0,   3'd0},  // R4 erased chunk
    {24'hFFFFFF, 24'h000001, 2'd3, 9'd0,   3'd0},  // R4 near miss -> R5
    {24'h000000, 24'hFFFFFF, 2'd3, 9'd0,   3'd0},  // R4 swapped -> R5
    {24'h000003, 24'h000000, 2'd3, 9'd0,   3'd0},  // R5 weight 2
    {24'h0007FF, 24'h000000, 2'd3, 9'd0,   3'd0},  // R5 weight 11
    {24'h001FFF, 24'h000000, 2'd3, 9'd0,   3'd0},  // R5 weight 13
    {24'h0F00FF, 24'h0F00FF, 2'd0, 9'd0,   3'd0}   // R1 clean after fix pattern
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_result(input string req, input logic [61:0] v);
    chk({req, " valid"},  int'(out_valid),  1);
    chk({req, " status"}, int'(out_status), int'(v[13:12]));
    chk({req, " byte"},   int'(out_byte),   int'(v[11:3]));
    chk({req, " bit"},    int'(out_bit),    int'(v[2:0]));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk);
    chk("R8 reset valid",  int'(out_valid),  0);
    chk("R8 reset status", int'(out_status), 0);
    chk("R8 reset byte",   int'(out_byte),   0);
    chk("R8 reset bit",    int'(out_bit),    0);
    chk("R8 reset ready",  int'(in_ready),   0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 ready after release", int'(in_ready), 1);
    chk("R7 no pulse when idle", int'(out_valid), 0);

    // Table walk, one pair at a time
    for (int i = 0; i < NV; i++) begin
      stored_code = VECS[i][61:38];
      calc_code   = VECS[i][37:14];
      in_valid    = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_result($sformatf("R1-table vec%0d", i), VECS[i]);
      // R6: any status other than 1 carries a zero address
      if (out_status != 2'd1) begin
        chk("R6 byte zero", int'(out_byte), 0);
        chk("R6 bit zero",  int'(out_bit),  0);
      end
    end

    // R7 hold: result stays while idle, valid low, even if codes change
    stored_code = 24'h000001;
    calc_code   = 24'h000000;
    @(negedge clk);
    chk("R7 valid drops", int'(out_valid), 0);
    @(negedge clk);
    chk("R7 status held", int'(out_status), 0);
    chk("R7 no pulse without in_valid", int'(out_valid), 0);

    // R7 back to back: corrected then uncorrectable
    stored_code = 24'h5AA35C; calc_code = 24'h000000; in_valid = 1'b1;
    @(negedge clk);
    check_result("R7 b2b first R2", {24'h0, 24'h0, 2'd1, 9'd180, 3'd3});
    stored_code = 24'h000003; calc_code = 24'h000000;
    @(negedge clk);
    in_valid = 1'b0;
    check_result("R7 b2b second R5", {24'h0, 24'h0, 2'd3, 9'd0, 3'd0});
    @(negedge clk);
    chk("R7 single pulse", int'(out_valid), 0);
    chk("R6 held zero byte", int'(out_byte), 0);

    // R8 reset in mid-run clears the result
    stored_code = 24'hF0FF00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R8 async clear status", int'(out_status), 0);
    chk("R8 async clear byte",   int'(out_byte),   0);
    chk("R8 async clear valid",  int'(out_valid),  0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule